// File: doc/BRIEF.md
# Dual-port synchronous SRAM access scheduler

This block is the core of a synchronous SRAM that has a separate read port and a separate write port but only one input clock. On every rising edge it looks at the two port selects and starts at most one transaction. Which port wins depends on what the previous edge started. Reads and writes each move a two-word burst of 18-bit words. The words sit at an even address and at the odd address just above it.

A write takes its first data word on the edge that starts it and its second word on the following edge. Each word carries two lane enables, one for each 9-bit half. Each word is held in a staging register for one cycle and then merged into the array. A read looks up its burst one cycle after it starts. If the staging register holds a word for the same address, the staged value is merged in ahead of the array, so the read returns the newest data. The two read words leave the block on consecutive cycles. A valid flag runs one cycle ahead of the data.

Top module: `sdp_sram_sched`

## Requirements
- R1: While reset is high, and on the first edge after it, `rd_valid` and `rd_data` are zero. Reset returns the previous-start state to idle and drops any burst in flight, so the first edge with both selects high after reset starts a read.
- R2: A write request on the edge right after an edge that started a write is ignored, so writes start at most on every other edge.
- R3: A read request on the edge right after an edge that started a read is ignored. No edge starts both a read and a write.
- R4: When both selects are high on an edge and the previous edge started nothing, the read starts.
- R5: When both selects are high, a read on the previous edge makes the write start, and a write on the previous edge makes the read start. Holding both selects from idle therefore gives read, write, read, write.
- R6: A write started with address A stores the word on `wr_data` at that edge to A with bit 0 cleared. It stores the word on `wr_data` at the next edge to A with bit 0 set. The second word is taken whatever `wr_sel` is on that edge.
- R7: `wr_be[0]` enables bits 8:0 and `wr_be[1]` enables bits 17:9 of the word sampled with it. A low enable leaves that half of the stored word unchanged.
- R8: A read started on edge e with address A drives the word at A with bit 0 cleared on `rd_data` after edge e+2. It drives the word at A with bit 0 set after edge e+3.
- R9: `rd_valid` is high after edges e+1 and e+2 of a read started on edge e. It leads each data beat by one cycle and is low when no read is in flight.
- R10: A read started on the edge after a write to the same burst returns both newly written words, including the second word, which was sampled on the read's own start edge.
- R11: A read started one edge before a write to the same burst returns the data stored before that write.
- R12: Dropping one port's select has no effect on the other port's requests, and a read that has started still returns its data after `rd_sel` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single input clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| rd_sel | input | 1 | Read port select |
| rd_addr | input | log2(DEPTH) | Read burst address (bit 0 ignored) |
| wr_sel | input | 1 | Write port select |
| wr_addr | input | log2(DEPTH) | Write burst address (bit 0 ignored) |
| wr_data | input | 18 | Write data word, sampled on the start edge and the edge after |
| wr_be | input | 2 | Per-half write enables sampled with each data word |
| rd_data | output | 18 | Read data beat |
| rd_valid | output | 1 | Read valid flag, one cycle ahead of each beat |

## Verification
The hardest case to reach from the ports is a read whose lookup happens while the second word of a write to the same burst is still in the staging register. That word has not reached the array yet, so only the forwarding path can supply it. The stimulus starts a write on one edge and, on the very next edge, raises `rd_sel` for the same address while presenting the write's second data word with a partial lane mask. The opposite ordering, a read followed one edge later by a write to its burst, is also driven, to show that forwarding does not pull in data from a later write. A pseudo-random stretch of select patterns over a small address range then mixes these cases with the arbitration rules.

// File: rtl/sdp_pkg.sv
package sdp_pkg;

    localparam int LANE_W = 9;
    localparam int LANES  = 2;
    localparam int WORD_W = LANE_W * LANES;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [LANES-1:0]  lane_en_t;

    typedef enum logic [1:0] {
        START_NONE = 2'd0,
        START_RD   = 2'd1,
        START_WR   = 2'd2
    } start_e;

    typedef struct packed {
        word_t    data;
        lane_en_t en;
    } beat_t;

    function automatic word_t lane_merge(word_t old_w, word_t new_w, lane_en_t en);
        word_t res;
        res = old_w;
        for (int i = 0; i < LANES; i++) begin
            if (en[i]) res[i*LANE_W +: LANE_W] = new_w[i*LANE_W +: LANE_W];
        end
        return res;
    endfunction

endpackage

// File: rtl/sdp_arbiter.sv
module sdp_arbiter
    import sdp_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic rd_req,
    input  logic wr_req,
    output logic rd_go,
    output logic wr_go
);

    start_e last_q;

    always_comb begin
        rd_go = 1'b0;
        wr_go = 1'b0;
        if (!rst) begin
            if (rd_req && wr_req) begin
                if (last_q == START_RD) wr_go = 1'b1;
                else                    rd_go = 1'b1;
            end else if (rd_req) begin
                rd_go = (last_q != START_RD);
            end else if (wr_req) begin
                wr_go = (last_q != START_WR);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)        last_q <= START_NONE;
        else if (rd_go) last_q <= START_RD;
        else if (wr_go) last_q <= START_WR;
        else            last_q <= START_NONE;
    end

endmodule

// File: rtl/sdp_wr_pipe.sv
module sdp_wr_pipe
    import sdp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  word_t         data,
    input  lane_en_t      en,
    output logic          stg_v,
    output logic [AW-1:0] stg_addr,
    output beat_t         stg_beat
);

    logic second_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            stg_v    <= 1'b0;
            second_q <= 1'b0;
            stg_addr <= '0;
            stg_beat <= '0;
        end else if (start) begin
            stg_v    <= 1'b1;
            second_q <= 1'b1;
            stg_addr <= {addr[AW-1:1], 1'b0};
            stg_beat <= '{data: data, en: en};
        end else if (second_q) begin
            stg_v    <= 1'b1;
            second_q <= 1'b0;
            stg_addr <= {stg_addr[AW-1:1], 1'b1};
            stg_beat <= '{data: data, en: en};
        end else begin
            stg_v    <= 1'b0;
        end
    end

endmodule

// File: rtl/sdp_store.sv
module sdp_store
    import sdp_pkg::*;
#(
    parameter int DEPTH = 256,
    parameter int AW    = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  beat_t         wbeat,
    input  logic [AW-1:0] raddr_a,
    input  logic [AW-1:0] raddr_b,
    output word_t         rdata_a,
    output word_t         rdata_b
);

    word_t mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= lane_merge(mem[waddr], wbeat.data, wbeat.en);
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/sdp_rd_pipe.sv
module sdp_rd_pipe
    import sdp_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  word_t         mem_a,
    input  word_t         mem_b,
    input  logic          stg_v,
    input  logic [AW-1:0] stg_addr,
    input  beat_t         stg_beat,
    output logic [AW-1:0] look_a,
    output logic [AW-1:0] look_b,
    output word_t         rd_data,
    output logic          rd_valid
);

    logic          p1_q, p2_q, p3_q;
    logic [AW-1:0] p1_addr;
    word_t         buf_q [2];
    word_t         word_a, word_b;

    assign look_a = {p1_addr[AW-1:1], 1'b0};
    assign look_b = {p1_addr[AW-1:1], 1'b1};

    always_comb begin
        word_a = mem_a;
        word_b = mem_b;
        if (stg_v && stg_addr == look_a) word_a = lane_merge(mem_a, stg_beat.data, stg_beat.en);
        if (stg_v && stg_addr == look_b) word_b = lane_merge(mem_b, stg_beat.data, stg_beat.en);
    end

    always_ff @(posedge clk) begin
        if (start) p1_addr <= addr;
        if (p1_q) begin
            buf_q[0] <= word_a;
            buf_q[1] <= word_b;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p1_q     <= 1'b0;
            p2_q     <= 1'b0;
            p3_q     <= 1'b0;
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            p1_q     <= start;
            p2_q     <= p1_q;
            p3_q     <= p2_q;
            rd_valid <= p1_q | p2_q;
            if (p2_q)      rd_data <= buf_q[0];
            else if (p3_q) rd_data <= buf_q[1];
        end
    end

endmodule

// File: rtl/sdp_sram_sched.sv
module sdp_sram_sched
    import sdp_pkg::*;
#(
    parameter  int DEPTH = 256,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_sel,
    input  logic [AW-1:0]     rd_addr,
    input  logic              wr_sel,
    input  logic [AW-1:0]     wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [LANES-1:0]  wr_be,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_valid
);

    logic          rd_go, wr_go;
    logic          stg_v;
    logic [AW-1:0] stg_addr;
    beat_t         stg_beat;
    logic [AW-1:0] look_a, look_b;
    word_t         mem_a, mem_b;

    sdp_arbiter u_arb (
        .clk    (clk),
        .rst    (rst),
        .rd_req (rd_sel),
        .wr_req (wr_sel),
        .rd_go  (rd_go),
        .wr_go  (wr_go)
    );

    sdp_wr_pipe #(.AW(AW)) u_wr (
        .clk      (clk),
        .rst      (rst),
        .start    (wr_go),
        .addr     (wr_addr),
        .data     (wr_data),
        .en       (wr_be),
        .stg_v    (stg_v),
        .stg_addr (stg_addr),
        .stg_beat (stg_beat)
    );

    sdp_store #(.DEPTH(DEPTH), .AW(AW)) u_mem (
        .clk     (clk),
        .we      (stg_v && !rst),
        .waddr   (stg_addr),
        .wbeat   (stg_beat),
        .raddr_a (look_a),
        .raddr_b (look_b),
        .rdata_a (mem_a),
        .rdata_b (mem_b)
    );

    sdp_rd_pipe #(.AW(AW)) u_rd (
        .clk      (clk),
        .rst      (rst),
        .start    (rd_go),
        .addr     (rd_addr),
        .mem_a    (mem_a),
        .mem_b    (mem_b),
        .stg_v    (stg_v),
        .stg_addr (stg_addr),
        .stg_beat (stg_beat),
        .look_a   (look_a),
        .look_b   (look_b),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: rtl/sdp_sched_chk.sv
module sdp_sched_chk (
    input logic clk,
    input logic rst,
    input logic rd_sel,
    input logic wr_sel,
    input logic rd_go,
    input logic wr_go,
    input logic rd_valid
);

    assert_wr_spacing_R2: assert property (@(posedge clk) disable iff (rst)
        wr_go |=> !wr_go);

    assert_rd_spacing_R3: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> !rd_go);

    assert_single_start_R3: assert property (@(posedge clk) disable iff (rst)
        rd_go |-> !wr_go);

    assert_idle_read_first_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_sel && wr_sel && !$past(rd_go) && !$past(wr_go)) |-> rd_go);

    assert_write_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(rd_go) && wr_sel) |-> wr_go);

    assert_read_after_write_R5: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_go) && rd_sel) |-> rd_go);

    assert_valid_lead_R9: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> ##1 rd_valid);

    assert_valid_width_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_valid) |=> rd_valid);

endmodule

bind sdp_sram_sched sdp_sched_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .rd_sel   (rd_sel),
    .wr_sel   (wr_sel),
    .rd_go    (rd_go),
    .wr_go    (wr_go),
    .rd_valid (rd_valid)
);

// File: tb/test_sdp_sram_sched.sv
module test_sdp_sram_sched;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rd_sel = 1'b0, wr_sel = 1'b0;
    logic [7:0]  rd_addr = '0, wr_addr = '0;
    logic [17:0] wr_data = '0;
    logic [1:0]  wr_be = '0;
    logic [17:0] rd_data;
    logic        rd_valid;

    sdp_sram_sched i_sdp_sram_sched (
        .clk(clk), .rst(rst),
        .rd_sel(rd_sel), .rd_addr(rd_addr),
        .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_be(wr_be),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #10 clk = ~clk;

    typedef struct {
        int          at;
        logic [17:0] d;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    bit          exp_v [0:4095];
    logic [17:0] ref_m [0:255];
    int          edges = 0;
    int          nchk = 0, nfail = 0;
    int          bprev = 0;
    bit          pend = 0;
    int          pend_a = 0;
    bit          run = 0, done = 0;
    string       cur_tag = "R1";

    always @(posedge clk) edges <= edges + 1;

    function automatic logic [17:0] mrg(logic [17:0] o, logic [17:0] n, logic [1:0] be);
        return {be[1] ? n[17:9] : o[17:9], be[0] ? n[8:0] : o[8:0]};
    endfunction

    function automatic logic [17:0] dv(int a, int b);
        return 18'(a * 1237 + b * 77 + 5);
    endfunction

    task automatic step(bit rs, bit ws, int ra, int wa, logic [17:0] d, logic [1:0] be, string tag);
        int  e;
        bit  rg, wg;
        int  base;
        @(negedge clk);
        rd_sel = rs; wr_sel = ws;
        rd_addr = 8'(ra); wr_addr = 8'(wa);
        wr_data = d; wr_be = be;
        e = edges + 1;
        if (pend) begin
            ref_m[pend_a] = mrg(ref_m[pend_a], d, be);
            pend = 0;
        end
        rg = 0; wg = 0;
        if (rs && ws) begin
            if (bprev == 1) wg = 1; else rg = 1;
        end else if (rs) rg = (bprev != 1);
        else if (ws) wg = (bprev != 2);
        bprev = rg ? 1 : (wg ? 2 : 0);
        if (wg) begin
            ref_m[wa & 'hFE] = mrg(ref_m[wa & 'hFE], d, be);
            pend = 1;
            pend_a = (wa & 'hFF) | 1;
        end
        if (rg) begin
            base = ra & 'hFE;
            sb.push_back('{at: e + 2, d: ref_m[base],     tag: tag});
            sb.push_back('{at: e + 3, d: ref_m[base | 1], tag: tag});
            if (e + 2 < 4096) begin
                exp_v[e + 1] = 1'b1;
                exp_v[e + 2] = 1'b1;
            end
        end
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, 0, 18'h0, 2'b00, cur_tag);
    endtask

    // scoreboard monitor: checks valid every cycle and pops expected data beats
    always @(negedge clk) begin
        if (run) begin
            nchk++;
            if (rd_valid !== exp_v[edges]) begin
                nfail++;
                $display("FAIL %s: rd_valid at edge %0d actual %b expected %b", cur_tag, edges, rd_valid, exp_v[edges]);
            end
            if (sb.size() > 0 && sb[0].at == edges) begin
                exp_t x;
                x = sb.pop_front();
                nchk++;
                if (rd_data !== x.d) begin
                    nfail++;
                    $display("FAIL %s: rd_data at edge %0d actual %h expected %h", x.tag, edges, rd_data, x.d);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lf;
        // R1: outputs cleared while in reset
        repeat (3) begin
            @(negedge clk);
            nchk++;
            if (rd_valid !== 1'b0 || rd_data !== 18'h0) begin
                nfail++;
                $display("FAIL R1: reset outputs actual %b/%h expected 0/0", rd_valid, rd_data);
            end
        end
        @(negedge clk);
        rst = 1'b0;
        run = 1'b1;

        // R1/R4: both selects right after reset start a read, the write is dropped
        cur_tag = "R1";
        step(1, 1, 'h20, 'h22, dv(99, 0), 2'b11, "R1");
        idle(5);

        // R6: fill bursts 0..31 (second word taken with wr_sel low)
        cur_tag = "R6";
        for (int i = 0; i < 16; i++) begin
            step(0, 1, 0, 2 * i, dv(i, 0), 2'b11, "R6");
            step(0, 0, 0, 0, dv(i, 1), 2'b11, "R6");
        end
        idle(2);

        // R8: plain read of a burst, odd address given
        cur_tag = "R8";
        step(1, 0, 'h11, 0, 18'h0, 2'b00, "R8");
        idle(5);

        // R4 / R5: both selects held from idle alternate read, write
        cur_tag = "R5";
        for (int i = 0; i < 6; i++) step(1, 1, 'h04, 'h08, dv(40 + i, 3), 2'b11, "R5");
        idle(5);
        step(1, 0, 'h08, 0, 18'h0, 2'b00, "R5");
        idle(5);

        // R2: write held every cycle, every other request ignored
        cur_tag = "R2";
        for (int i = 0; i < 5; i++) step(0, 1, 0, 'h0C + 2 * (i % 2), dv(60 + i, 1), 2'b11, "R2");
        idle(3);
        step(1, 0, 'h0C, 0, 18'h0, 2'b00, "R2");
        idle(2);

        // R3: read held every cycle, starts on alternate edges
        cur_tag = "R3";
        for (int i = 0; i < 4; i++) step(1, 0, 'h0C + 2 * (i % 2), 0, 18'h0, 2'b00, "R3");
        idle(6);

        // R7: half-word enables
        cur_tag = "R7";
        step(0, 1, 0, 'h14, 18'h3FFFF, 2'b01, "R7");
        step(0, 0, 0, 0, 18'h3FFFF, 2'b10, "R7");
        idle(2);
        step(1, 0, 'h14, 0, 18'h0, 2'b00, "R7");
        idle(5);

        // R10: read on the edge right after a write, second word still staged
        cur_tag = "R10";
        step(0, 1, 0, 'h18, 18'h2AAAA, 2'b11, "R10");
        step(1, 0, 'h19, 0, 18'h15555, 2'b10, "R10");
        idle(6);

        // R11: read one edge before a write to the same burst sees old data
        cur_tag = "R11";
        step(1, 0, 'h1C, 0, 18'h0, 2'b00, "R11");
        step(0, 1, 0, 'h1C, 18'h0BEEF, 2'b11, "R11");
        step(0, 0, 0, 0, 18'h1CAFE, 2'b11, "R11");
        idle(2);
        step(1, 0, 'h1C, 0, 18'h0, 2'b00, "R11");
        idle(5);

        // R12: read select drops after start, write select drops during burst
        cur_tag = "R12";
        step(1, 0, 'h02, 0, 18'h0, 2'b00, "R12");
        step(0, 1, 0, 'h06, 18'h01234, 2'b11, "R12");
        step(1, 0, 'h06, 0, 18'h04321, 2'b11, "R12");
        step(0, 0, 0, 0, 18'h0, 2'b00, "R12");
        idle(5);

        // R5: pseudo-random select patterns over the filled range
        cur_tag = "R5";
        lf = 16'hACE1;
        for (int i = 0; i < 80; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[0], lf[1], {28'h0, lf[4:2], 1'b0}, {28'h0, lf[9:7], 1'b0}, dv(200 + i, 2), lf[6:5], "R5");
        end
        idle(8);

        // R8: every expected beat was delivered
        nchk++;
        if (sb.size() != 0) begin
            nfail++;
            $display("FAIL R8: pending beats actual %0d expected 0", sb.size());
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

endmodule